// File: doc/BRIEF.md
# Ramp Offset Background Calibrator

This block removes the offsets between the ramps of a multiple-ramp single-slope column converter without any analog trimming. A spare test column, whose comparator is permanently wired to the first ramp (the reference ramp), converts voltages that are meant to sit at the middle of each of the other ramps. The block points the test-voltage source at one ramp at a time. It subtracts the ideal midpoint code from every test result and averages the differences over a power-of-two batch. The result is the measured offset of that ramp against the reference.

Each averaged offset moves the start code of its ramp. When a normal column delivers its coarse result (which ramp it used) and its fine count, the block adds the fine count to the calibrated start code of that ramp and clamps the sum to the output code range. The test conversions run in the background while pixel data move into the front-end amplifiers. A new start code is only put to use while no conversion is in progress, so one line is never converted with two different tables.

Top module: `ramp_offset_cal`

## Requirements
- R1: After reset, out_valid is 0, out_code is 0, cal_ramp is 1 and every ramp offset is zero, so coarse k with fine f yields k*128+f.
- R2: cal_ramp holds the ramp index (1..7) being measured. It changes only on an accepted test sample and advances by one after every 16th sample of a batch, wrapping from 7 back to 1.
- R3: The ideal test code for ramp index k is k*128+64. The batch offset is floor(sum over 16 samples of (tst_code - ideal) / 16), with rounding toward minus infinity.
- R4: One cycle after cnv_valid, out_valid is 1 and out_code equals the start code of ramp cnv_coarse (cnv_coarse*128 + its offset) plus cnv_fine. out_valid is 0 in the cycle after a cycle without cnv_valid.
- R5: A combined code below 0 gives 0, and one above 1023 gives 1023.
- R6: Ramp index 0 is the reference. Its start code is always 0, so coarse 0 outputs the fine count unchanged.
- R7: While conv_active is high, the table used for combining does not change. A completed batch takes effect within 3 cycles once conv_active is low.
- R8: A batch of fewer than 16 samples changes no output. Each new batch starts from an empty sum, so earlier batches do not leak into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_active | input | 1 | High while a line conversion is running; the start-code table is frozen |
| tst_valid | input | 1 | A test-column result is present this cycle |
| tst_code | input | 10 | Test-column result |
| cal_ramp | output | 3 | Ramp index whose midpoint the test source must drive |
| cnv_valid | input | 1 | A column result is present this cycle |
| cnv_coarse | input | 3 | Ramp index chosen by the coarse phase |
| cnv_fine | input | 7 | Fine-phase count |
| out_valid | output | 1 | out_code is valid |
| out_code | output | 10 | Calibrated, saturated final code |

## Verification
The hardest cases to reach from the ports are the two clamps and the freeze of the table. The clamps need offsets large enough to push a start code outside the code range. The bench drives test results at the extremes of the code range (0 and 1023) for the last two ramps. The freeze needs a batch to complete while a line is still running. The bench raises conv_active before it feeds a full batch, converts against the stale table, then lowers conv_active and converts again to see the new start code. A partial batch of 15 samples, followed by a batch of zero differences on a fresh ramp, shows that the sum is neither applied early nor carried over into the next batch.

// File: rtl/rcal_pkg.sv
// Package: default geometry shared by the ramp offset calibrator.
// Assumes the output code width equals ramp-select width plus fine width.
package rcal_pkg;
    localparam int DEF_NUM_RAMPS = 8;
    localparam int DEF_SEL_W     = 3;
    localparam int DEF_FINE_W    = 7;
    localparam int DEF_OUT_W     = DEF_SEL_W + DEF_FINE_W;
    localparam int DEF_AVG_LOG2  = 4;
    localparam int DEF_OFF_W     = DEF_OUT_W + 2;
endpackage

// File: rtl/rcal_accum.sv
// Module: rcal_accum
// Collects test-column results for one ramp at a time, averages 2**AVG_LOG2
// differences against the ramp midpoint with a shift, then moves to the next ramp.
// Assumes AVG_LOG2 >= 1 and ramp indices 1..NUM_RAMPS-1 are calibrated.
module rcal_accum #(
    parameter int NUM_RAMPS = rcal_pkg::DEF_NUM_RAMPS,
    parameter int SEL_W     = rcal_pkg::DEF_SEL_W,
    parameter int FINE_W    = rcal_pkg::DEF_FINE_W,
    parameter int OUT_W     = rcal_pkg::DEF_OUT_W,
    parameter int AVG_LOG2  = rcal_pkg::DEF_AVG_LOG2,
    parameter int OFF_W     = rcal_pkg::DEF_OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tst_valid,
    input  logic [OUT_W-1:0]        tst_code,
    output logic [SEL_W-1:0]        cal_ramp,
    output logic                    upd_valid,
    output logic [SEL_W-1:0]        upd_ramp,
    output logic signed [OFF_W-1:0] upd_off
);
    localparam int ACC_W = OFF_W + AVG_LOG2;
    localparam logic [SEL_W-1:0] LAST_SEL  = SEL_W'(NUM_RAMPS - 1);
    localparam logic [SEL_W-1:0] FIRST_SEL = SEL_W'(1);

    logic [SEL_W-1:0]        sel_q;
    logic [AVG_LOG2-1:0]     cnt_q;
    logic signed [ACC_W-1:0] acc_q;
    logic [OUT_W-1:0]        ideal;
    logic signed [OFF_W-1:0] diff;
    logic signed [ACC_W-1:0] acc_nxt;

    // Midpoint code of the ramp under test and the sample's signed error.
    always_comb begin
        ideal   = {sel_q, 1'b1, {(FINE_W-1){1'b0}}};
        diff    = $signed({2'b00, tst_code}) - $signed({2'b00, ideal});
        acc_nxt = acc_q + {{AVG_LOG2{diff[OFF_W-1]}}, diff};
    end

    // Batch accumulation, averaging by shift and round-robin ramp stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= FIRST_SEL;
            cnt_q     <= '0;
            acc_q     <= '0;
            upd_valid <= 1'b0;
            upd_ramp  <= '0;
            upd_off   <= '0;
        end else begin
            upd_valid <= 1'b0;
            if (tst_valid) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '1) begin
                    acc_q     <= '0;
                    upd_valid <= 1'b1;
                    upd_ramp  <= sel_q;
                    upd_off   <= acc_nxt[ACC_W-1:AVG_LOG2];
                    sel_q     <= (sel_q == LAST_SEL) ? FIRST_SEL : sel_q + 1'b1;
                end else begin
                    acc_q <= acc_nxt;
                end
            end
        end
    end

    assign cal_ramp = sel_q;
endmodule

// File: rtl/rcal_table.sv
// Module: rcal_table
// Holds a pending and an active offset per ramp. Pending entries take new
// averages at any time; the active copy follows only while no conversion runs.
// Assumes entry 0 is the reference and stays zero.
module rcal_table #(
    parameter int NUM_RAMPS = rcal_pkg::DEF_NUM_RAMPS,
    parameter int SEL_W     = rcal_pkg::DEF_SEL_W,
    parameter int OFF_W     = rcal_pkg::DEF_OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_valid,
    input  logic [SEL_W-1:0]           upd_ramp,
    input  logic signed [OFF_W-1:0]    upd_off,
    input  logic                       conv_active,
    output logic [NUM_RAMPS*OFF_W-1:0] act_flat
);
    assign act_flat[OFF_W-1:0] = '0;

    for (genvar g = 1; g < NUM_RAMPS; g++) begin : g_entry
        logic [OFF_W-1:0] pend_q;
        logic [OFF_W-1:0] act_q;

        // Capture a finished average for this ramp.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q <= '0;
            else if (upd_valid && upd_ramp == SEL_W'(g))
                pend_q <= upd_off;
        end

        // Copy into the active table only between conversions.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q <= '0;
            else if (!conv_active)
                act_q <= pend_q;
        end

        assign act_flat[g*OFF_W +: OFF_W] = act_q;
    end
endmodule

// File: rtl/rcal_combine.sv
// Module: rcal_combine
// Forms the final code as calibrated start code plus fine count, clamped to
// the output range, registered once. Assumes OUT_W = SEL_W + FINE_W.
module rcal_combine #(
    parameter int NUM_RAMPS = rcal_pkg::DEF_NUM_RAMPS,
    parameter int SEL_W     = rcal_pkg::DEF_SEL_W,
    parameter int FINE_W    = rcal_pkg::DEF_FINE_W,
    parameter int OUT_W     = rcal_pkg::DEF_OUT_W,
    parameter int OFF_W     = rcal_pkg::DEF_OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnv_valid,
    input  logic [SEL_W-1:0]           cnv_coarse,
    input  logic [FINE_W-1:0]          cnv_fine,
    input  logic [NUM_RAMPS*OFF_W-1:0] act_flat,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_code
);
    localparam int SUM_W = OFF_W + 1;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

    logic signed [OFF_W-1:0] off;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        sat;

    // Start code plus fine count, then clamp.
    always_comb begin
        off = act_flat[cnv_coarse*OFF_W +: OFF_W];
        sum = $signed({{(SUM_W-OUT_W){1'b0}}, cnv_coarse, cnv_fine})
            + $signed({off[OFF_W-1], off});
        if (sum < 0)
            sat = '0;
        else if (sum > MAXV)
            sat = '1;
        else
            sat = sum[OUT_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= cnv_valid;
            if (cnv_valid)
                out_code <= sat;
        end
    end
endmodule

// File: rtl/ramp_offset_cal.sv
// Module: ramp_offset_cal (top)
// Background ramp offset calibration: measures each non-reference ramp with a
// test column, averages, and corrects start codes when codes are combined.
// Assumes the test voltage source follows cal_ramp.
module ramp_offset_cal #(
    parameter int NUM_RAMPS = rcal_pkg::DEF_NUM_RAMPS,
    parameter int SEL_W     = rcal_pkg::DEF_SEL_W,
    parameter int FINE_W    = rcal_pkg::DEF_FINE_W,
    parameter int AVG_LOG2  = rcal_pkg::DEF_AVG_LOG2,
    localparam int OUT_W    = SEL_W + FINE_W,
    localparam int OFF_W    = OUT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_active,
    input  logic              tst_valid,
    input  logic [OUT_W-1:0]  tst_code,
    output logic [SEL_W-1:0]  cal_ramp,
    input  logic              cnv_valid,
    input  logic [SEL_W-1:0]  cnv_coarse,
    input  logic [FINE_W-1:0] cnv_fine,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_code
);
    logic                       upd_valid;
    logic [SEL_W-1:0]           upd_ramp;
    logic signed [OFF_W-1:0]    upd_off;
    logic [NUM_RAMPS*OFF_W-1:0] act_flat;

    rcal_accum #(.NUM_RAMPS(NUM_RAMPS), .SEL_W(SEL_W), .FINE_W(FINE_W),
                 .OUT_W(OUT_W), .AVG_LOG2(AVG_LOG2), .OFF_W(OFF_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .tst_valid(tst_valid), .tst_code(tst_code),
        .cal_ramp(cal_ramp), .upd_valid(upd_valid), .upd_ramp(upd_ramp),
        .upd_off(upd_off)
    );

    rcal_table #(.NUM_RAMPS(NUM_RAMPS), .SEL_W(SEL_W), .OFF_W(OFF_W)) u_table (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ramp(upd_ramp),
        .upd_off(upd_off), .conv_active(conv_active), .act_flat(act_flat)
    );

    rcal_combine #(.NUM_RAMPS(NUM_RAMPS), .SEL_W(SEL_W), .FINE_W(FINE_W),
                   .OUT_W(OUT_W), .OFF_W(OFF_W)) u_combine (
        .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .cnv_coarse(cnv_coarse),
        .cnv_fine(cnv_fine), .act_flat(act_flat), .out_valid(out_valid),
        .out_code(out_code)
    );
endmodule

// File: rtl/rcal_checker.sv
// Module: rcal_checker
// Protocol and invariant properties for ramp_offset_cal, attached by bind.
module rcal_checker #(
    parameter int NUM_RAMPS = 8,
    parameter int SEL_W     = 3,
    parameter int FINE_W    = 7,
    parameter int OUT_W     = 10,
    parameter int OFF_W     = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       conv_active,
    input logic                       tst_valid,
    input logic [SEL_W-1:0]           cal_ramp,
    input logic                       cnv_valid,
    input logic [SEL_W-1:0]           cnv_coarse,
    input logic [FINE_W-1:0]          cnv_fine,
    input logic                       out_valid,
    input logic [OUT_W-1:0]           out_code,
    input logic [NUM_RAMPS*OFF_W-1:0] act_flat
);
    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ramp != '0 && cal_ramp <= SEL_W'(NUM_RAMPS - 1));

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_valid |=> $stable(cal_ramp));

    p_out_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_valid |=> out_valid);

    p_out_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_valid |=> !out_valid);

    p_ref_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_valid && cnv_coarse == '0) |=> out_code == OUT_W'($past(cnv_fine)));

    p_table_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv_active) |-> $stable(act_flat));
endmodule

bind ramp_offset_cal rcal_checker #(
    .NUM_RAMPS(NUM_RAMPS), .SEL_W(SEL_W), .FINE_W(FINE_W),
    .OUT_W(OUT_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_active(conv_active), .tst_valid(tst_valid),
    .cal_ramp(cal_ramp), .cnv_valid(cnv_valid), .cnv_coarse(cnv_coarse),
    .cnv_fine(cnv_fine), .out_valid(out_valid), .out_code(out_code),
    .act_flat(act_flat)
);

// File: tb/tb_ramp_offset_cal.sv
// Directed bench for ramp_offset_cal: one task per scenario.
`timescale 1ns/1ps
module tb_ramp_offset_cal;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_active = 1'b0;
    logic       tst_valid = 1'b0;
    logic [9:0] tst_code = '0;
    logic [2:0] cal_ramp;
    logic       cnv_valid = 1'b0;
    logic [2:0] cnv_coarse = '0;
    logic [6:0] cnv_fine = '0;
    logic       out_valid;
    logic [9:0] out_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ramp_offset_cal dut (
        .clk(clk), .rst_n(rst_n), .conv_active(conv_active),
        .tst_valid(tst_valid), .tst_code(tst_code), .cal_ramp(cal_ramp),
        .cnv_valid(cnv_valid), .cnv_coarse(cnv_coarse), .cnv_fine(cnv_fine),
        .out_valid(out_valid), .out_code(out_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Feed one test sample at ideal+diff for the given ramp index.
    task automatic send_tst(input int ramp, input int diff);
        @(negedge clk);
        tst_valid = 1'b1;
        tst_code  = 10'(ramp * 128 + 64 + diff);
        @(negedge clk);
        tst_valid = 1'b0;
    endtask

    // Feed n samples: first half with diff a, the rest with diff b.
    task automatic send_batch(input int ramp, input int n, input int a, input int b);
        for (int i = 0; i < n; i++)
            send_tst(ramp, (i < 8) ? a : b);
    endtask

    // Present a column result and check the registered code one cycle later.
    task automatic convert(input string req, input int coarse, input int fine, input int exp);
        @(negedge clk);
        cnv_valid  = 1'b1;
        cnv_coarse = 3'(coarse);
        cnv_fine   = 7'(fine);
        @(negedge clk);
        cnv_valid = 1'b0;
        check(req, int'(out_valid), 1);
        check(req, int'(out_code), exp);
        @(negedge clk);
        check({req, " R4 valid drops"}, int'(out_valid), 0);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_code", int'(out_code), 0);
        check("R1 cal_ramp", int'(cal_ramp), 1);
        convert("R1 zero offset ramp3", 3, 17, 3*128+17);
        convert("R6 reference ramp", 0, 99, 99);
    endtask

    task automatic t_basic();
        send_batch(1, 16, 10, 10);
        check("R2 advance to 2", int'(cal_ramp), 2);
        settle();
        convert("R3/R4 ramp1 offset +10", 1, 5, 128+10+5);
    endtask

    task automatic t_floor();
        send_batch(2, 16, -3, 0);
        check("R2 advance to 3", int'(cal_ramp), 3);
        settle();
        convert("R3 floor of -1.5", 2, 0, 256-2);
        convert("R6 reference unchanged", 0, 77, 77);
    endtask

    task automatic t_partial();
        send_batch(3, 15, 40, 40);
        settle();
        check("R8 partial keeps ramp", int'(cal_ramp), 3);
        convert("R8 partial no effect", 3, 0, 384);
        send_tst(3, 40);
        settle();
        convert("R3 ramp3 offset +40", 3, 0, 424);
        send_batch(4, 16, 0, 0);
        settle();
        convert("R8 fresh sum ramp4", 4, 9, 512+9);
    endtask

    task automatic t_freeze();
        @(negedge clk) conv_active = 1'b1;
        send_batch(5, 16, 20, 20);
        settle();
        convert("R7 frozen during conversion", 5, 0, 640);
        @(negedge clk) conv_active = 1'b0;
        repeat (3) @(negedge clk);
        convert("R7 applied between conversions", 5, 0, 660);
    endtask

    task automatic t_saturate();
        send_batch(6, 16, -832, -832);
        check("R2 advance to 7", int'(cal_ramp), 7);
        send_batch(7, 16, 63, 63);
        check("R2 wrap to 1", int'(cal_ramp), 1);
        settle();
        convert("R5 clamp low", 6, 10, 0);
        convert("R5 clamp high", 7, 127, 1023);
        convert("R5 near top no clamp", 7, 64, 1023);
        convert("R4 ramp7 in range", 7, 0, 896+63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_floor();
        t_partial();
        t_freeze();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule